// File: doc/BRIEF.md
# ADC Regular Sequence Scan Controller

This controller drives an external analog-to-digital converter through a programmable list of conversion slots. Each slot names one of the converter's input channels. The list may contain channels in any order and may repeat a channel. Every input channel has its own sample-time code. The controller looks up the code from the channel that the current slot names, and holds a sample window open for the matching number of clock cycles. It then tells the converter to begin its conversion and waits for the converter's done strobe.

Each finished conversion produces a one-cycle end-of-conversion pulse. The controller latches the result together with the slot it came from and raises a DMA request, which stays up until the DMA side acknowledges it. A scan enable selects between converting the whole programmed list and converting only the first slot. A continuous enable makes the list start again from the first slot with no new trigger. Dropping the enable lets the conversion in flight finish, then parks the controller with its slot pointer back at the first slot.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `cnv_sample`, `cnv_start`, `eoc`, `dma_req` and `ovr` are all 0.
- R2: A `trig` pulse while idle with `en` high starts a sequence, and `busy` is 1 on the following cycle. A `trig` while `en` is low is ignored: no sample window opens and `busy` stays 0.
- R3: With `scan_en` high, a sequence converts slots 0, 1, ... up to `seq_len`, which is `seq_len`+1 conversions. Slot i is the field `slot_list[5*i +: 5]`. Channels may repeat across slots.
- R4: With `scan_en` low, a sequence converts only slot 0, whatever `seq_len` holds.
- R5: The sample window (`cnv_sample` high, with `cnv_ch` held steady) lasts 2, 8, 14, 29, 42, 56, 72 or 240 cycles for sample codes 0 to 7. The code is `smp_table[3*ch +: 3]` for the channel being sampled. `cnv_start` is high in the last cycle of the window only.
- R6: The cycle after `cnv_done` arrives during a conversion, `eoc` is high for one cycle. At the same time `res_data` shows the `cnv_data` that came with the done strobe, and `res_slot` shows the slot index of that conversion.
- R7: `dma_req` rises together with `eoc` and stays high until a cycle with `dma_ack` high.
- R8: If a conversion finishes while `dma_req` is still high and `dma_ack` is low in that cycle, `ovr` goes to 1 and the result registers take the newer data. `ovr` returns to 0 when the next sequence is started by a trigger.
- R9: With `cont_en` high, the conversion after the last slot is slot 0 again, and no trigger is needed.
- R10: Dropping `en` lets the conversion in progress finish with its `eoc`, then no further sample window opens. The next triggered sequence begins at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable |
| trig | input | 1 | Start pulse for a sequence |
| scan_en | input | 1 | Convert all slots up to `seq_len` when 1, only slot 0 when 0 |
| cont_en | input | 1 | Restart the list after the last slot |
| seq_len | input | 4 | Index of the last slot used |
| slot_list | input | 80 | Sixteen 5-bit channel numbers, slot i at bits 5*i |
| smp_table | input | 96 | Thirty-two 3-bit sample codes, channel c at bits 3*c |
| cnv_sample | output | 1 | Sample window open |
| cnv_start | output | 1 | Last sample cycle; converter begins converting |
| cnv_ch | output | 5 | Channel being sampled or converted |
| cnv_done | input | 1 | Converter finished, data valid |
| cnv_data | input | 12 | Converter result |
| eoc | output | 1 | End-of-conversion pulse |
| res_data | output | 12 | Latest conversion result |
| res_slot | output | 4 | Slot index of the latest result |
| dma_req | output | 1 | DMA request for the latest result |
| dma_ack | input | 1 | DMA acknowledge |
| ovr | output | 1 | Result overwritten before it was acknowledged |
| busy | output | 1 | Sequence in progress |

## Verification
The converter model answers every start with a result that encodes the channel and a running count. A result from the wrong conversion, or a stale result, therefore shows up at the `eoc` check. Random slot lists, lengths and sample tables exercise ordering and the duration lookup together. A directed list that holds each of the eight sample codes once separates a wrong duration from a wrong lookup index, and a list with repeated channels catches any code that is keyed by slot instead of by channel. Separate directed runs cover these cases:
- scan disabled with a long length, where the length must be ignored;
- continuous mode stopped through `en` at a known point, which distinguishes a clean stop with the pointer reset from a run-on or a resumed pointer;
- withheld acknowledges, which show the overrun flag and the overwrite.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int SMP_W     = 3;
  localparam int SMP_CNT_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seq_state_e;

  // Sample window length in clock cycles for each sample code.
  function automatic logic [SMP_CNT_W-1:0] smp_cycles(input logic [SMP_W-1:0] code);
    logic [SMP_CNT_W-1:0] len;
    case (code)
      3'd0:    len = 8'd2;
      3'd1:    len = 8'd8;
      3'd2:    len = 8'd14;
      3'd3:    len = 8'd29;
      3'd4:    len = 8'd42;
      3'd5:    len = 8'd56;
      3'd6:    len = 8'd72;
      default: len = 8'd240;
    endcase
    return len;
  endfunction

  // True when the slot just converted closes the pass through the list.
  function automatic logic pass_done(input logic scan, input logic [7:0] idx,
                                     input logic [7:0] last_idx);
    return !scan || (idx == last_idx);
  endfunction

endpackage

// File: rtl/adc_seq_slot_mux.sv
module adc_seq_slot_mux
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 5,
  localparam int LEN_W    = $clog2(NUM_SLOTS),
  localparam int NUM_CH   = 1 << CH_W
) (
  input  logic [NUM_SLOTS*CH_W-1:0] slot_list,
  input  logic [NUM_CH*SMP_W-1:0]   smp_table,
  input  logic [LEN_W-1:0]          slot_idx,
  output logic [CH_W-1:0]           cur_ch,
  output logic [SMP_CNT_W-1:0]      cur_smp_len
);

  logic [CH_W-1:0]  slot_arr [NUM_SLOTS];
  logic [SMP_W-1:0] code_arr [NUM_CH];
  logic [SMP_W-1:0] cur_code;

  for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
    assign slot_arr[gs] = slot_list[gs*CH_W +: CH_W];
  end

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_code
    assign code_arr[gc] = smp_table[gc*SMP_W +: SMP_W];
  end

  // The slot picks the channel; the channel picks its own sample code.
  assign cur_ch      = slot_arr[slot_idx];
  assign cur_code    = code_arr[cur_ch];
  assign cur_smp_len = smp_cycles(cur_code);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int LEN_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 trig,
  input  logic                 scan_en,
  input  logic                 cont_en,
  input  logic [LEN_W-1:0]     seq_len,
  input  logic [SMP_CNT_W-1:0] smp_len,
  input  logic                 cnv_done,
  output logic [LEN_W-1:0]     slot_idx,
  output logic                 cnv_sample,
  output logic                 cnv_start,
  output logic                 conv_fin,
  output logic                 seq_start,
  output logic                 busy
);

  seq_state_e           state_q, state_d;
  logic [LEN_W-1:0]     idx_q, idx_d;
  logic [SMP_CNT_W-1:0] cnt_q, cnt_d;
  logic                 last_slot;

  assign seq_start  = (state_q == ST_IDLE) && en && trig;
  assign cnv_sample = (state_q == ST_SAMPLE);
  // The counter runs up from zero, so the current slot's length is compared
  // directly and no look-ahead to the next slot is needed.
  assign cnv_start  = cnv_sample && (cnt_q == smp_len - 1'b1);
  assign conv_fin   = (state_q == ST_CONVERT) && cnv_done;
  assign last_slot  = pass_done(scan_en, 8'(idx_q), 8'(seq_len));
  assign busy       = (state_q != ST_IDLE);
  assign slot_idx   = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (seq_start) begin
          state_d = ST_SAMPLE;
          idx_d   = '0;
          cnt_d   = '0;
        end
      end
      ST_SAMPLE: begin
        if (cnv_start) state_d = ST_CONVERT;
        else           cnt_d   = cnt_q + 1'b1;
      end
      ST_CONVERT: begin
        if (conv_fin) begin
          cnt_d = '0;
          if (!en) begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end else if (!last_slot) begin
            state_d = ST_SAMPLE;
            idx_d   = idx_q + 1'b1;
          end else if (cont_en) begin
            state_d = ST_SAMPLE;
            idx_d   = '0;
          end else begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        idx_d   = '0;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int DATA_W = 12,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_fin,
  input  logic              seq_start,
  input  logic [DATA_W-1:0] cnv_data,
  input  logic [LEN_W-1:0]  slot_idx,
  input  logic              dma_ack,
  output logic              eoc,
  output logic [DATA_W-1:0] res_data,
  output logic [LEN_W-1:0]  res_slot,
  output logic              dma_req,
  output logic              ovr
);

  logic lost_result;

  // A finish that meets an unserved request with no ack in that cycle loses
  // the older result.
  assign lost_result = conv_fin && dma_req && !dma_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc      <= 1'b0;
      res_data <= '0;
      res_slot <= '0;
      dma_req  <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      eoc <= conv_fin;
      if (conv_fin) begin
        res_data <= cnv_data;
        res_slot <= slot_idx;
      end
      if (conv_fin)     dma_req <= 1'b1;
      else if (dma_ack) dma_req <= 1'b0;
      if (seq_start)        ovr <= 1'b0;
      else if (lost_result) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 5,
  parameter int DATA_W    = 12,
  localparam int LEN_W    = $clog2(NUM_SLOTS),
  localparam int NUM_CH   = 1 << CH_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      trig,
  input  logic                      scan_en,
  input  logic                      cont_en,
  input  logic [LEN_W-1:0]          seq_len,
  input  logic [NUM_SLOTS*CH_W-1:0] slot_list,
  input  logic [NUM_CH*SMP_W-1:0]   smp_table,
  output logic                      cnv_sample,
  output logic                      cnv_start,
  output logic [CH_W-1:0]           cnv_ch,
  input  logic                      cnv_done,
  input  logic [DATA_W-1:0]         cnv_data,
  output logic                      eoc,
  output logic [DATA_W-1:0]         res_data,
  output logic [LEN_W-1:0]          res_slot,
  output logic                      dma_req,
  input  logic                      dma_ack,
  output logic                      ovr,
  output logic                      busy
);

  // Named internal events shared between the sub-blocks.
  logic [LEN_W-1:0]     slot_idx;
  logic [SMP_CNT_W-1:0] smp_len;
  logic                 conv_fin;
  logic                 seq_start;

  adc_seq_slot_mux #(
    .NUM_SLOTS(NUM_SLOTS),
    .CH_W     (CH_W)
  ) i_slot_mux (
    .slot_list  (slot_list),
    .smp_table  (smp_table),
    .slot_idx   (slot_idx),
    .cur_ch     (cnv_ch),
    .cur_smp_len(smp_len)
  );

  adc_seq_fsm #(
    .NUM_SLOTS(NUM_SLOTS)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .trig      (trig),
    .scan_en   (scan_en),
    .cont_en   (cont_en),
    .seq_len   (seq_len),
    .smp_len   (smp_len),
    .cnv_done  (cnv_done),
    .slot_idx  (slot_idx),
    .cnv_sample(cnv_sample),
    .cnv_start (cnv_start),
    .conv_fin  (conv_fin),
    .seq_start (seq_start),
    .busy      (busy)
  );

  adc_seq_result #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) i_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_fin (conv_fin),
    .seq_start(seq_start),
    .cnv_data (cnv_data),
    .slot_idx (slot_idx),
    .dma_ack  (dma_ack),
    .eoc      (eoc),
    .res_data (res_data),
    .res_slot (res_slot),
    .dma_req  (dma_req),
    .ovr      (ovr)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            busy,
  input logic            cnv_sample,
  input logic            cnv_start,
  input logic [CH_W-1:0] cnv_ch,
  input logic            cnv_done,
  input logic            eoc,
  input logic            dma_req,
  input logic            dma_ack,
  input logic            ovr
);

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !cnv_sample);

  p_window_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_sample);

  p_channel_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_sample && !cnv_start) |=> (cnv_sample && $stable(cnv_ch)));

  p_eoc_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(cnv_done));

  p_eoc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);

  p_overrun_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && $past(dma_req) && !$past(dma_ack)) |-> ovr);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) i_chk (.*);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NS  = 16;
  localparam int CW  = 5;
  localparam int DW  = 12;
  localparam int NCH = 32;
  localparam int CONV_LAT = 12;
  localparam int WATCHDOG = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic            trig = 1'b0;
  logic            scan_en = 1'b0;
  logic            cont_en = 1'b0;
  logic [3:0]      seq_len = '0;
  logic [NS*CW-1:0] slot_list = '0;
  logic [NCH*3-1:0] smp_table = '0;
  logic            cnv_done = 1'b0;
  logic [DW-1:0]   cnv_data = '0;
  logic            auto_ack_q = 1'b0;
  logic            man_ack = 1'b0;
  wire             dma_ack = auto_ack_q || man_ack;
  logic            cnv_sample, cnv_start, eoc, dma_req, ovr, busy;
  logic [CW-1:0]   cnv_ch;
  logic [DW-1:0]   res_data;
  logic [3:0]      res_slot;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .scan_en(scan_en),
    .cont_en(cont_en), .seq_len(seq_len), .slot_list(slot_list),
    .smp_table(smp_table), .cnv_sample(cnv_sample), .cnv_start(cnv_start),
    .cnv_ch(cnv_ch), .cnv_done(cnv_done), .cnv_data(cnv_data), .eoc(eoc),
    .res_data(res_data), .res_slot(res_slot), .dma_req(dma_req),
    .dma_ack(dma_ack), .ovr(ovr), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_eoc = 0;
  int pos = 0, lap = 0, run = 0, cd = 0, gen = 0, slot_at_start = 0;
  bit auto_ack = 1'b1;
  bit after_stop = 1'b0;
  logic [DW-1:0] last_data = '0;

  function automatic int exp_smp(int code);
    int t [8] = '{2, 8, 14, 29, 42, 56, 72, 240};
    return t[code & 7];
  endfunction

  function automatic int slot_ch(int i);
    return int'(slot_list[i*CW +: CW]);
  endfunction

  function automatic int ch_code(int ch);
    return int'(smp_table[ch*3 +: 3]);
  endfunction

  function automatic int exp_count();
    return scan_en ? int'(seq_len) + 1 : 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter model, acknowledge driver and conversion monitor.
  always @(negedge clk) begin : mon
    string tag;
    if (rst_n) begin
      cnv_done = 1'b0;
      if (cd > 0) begin
        cd = cd - 1;
        if (cd == 0) cnv_done = 1'b1;
      end
      auto_ack_q = auto_ack && dma_req;
      if (eoc) begin
        n_eoc++;
        check(res_data == last_data, "R6 data", int'(res_data), int'(last_data));
        check(int'(res_slot) == slot_at_start, "R6 slot", int'(res_slot), slot_at_start);
        check(dma_req, "R7 req with eoc", int'(dma_req), 1);
      end
      if (cnv_sample) run++;
      else            run = 0;
      if (cnv_start) begin
        tag = after_stop ? "R10 restart slot" : (lap > 0 ? "R9 wrap slot" : "R3 slot order");
        check(int'(cnv_ch) == slot_ch(pos), tag, int'(cnv_ch), slot_ch(pos));
        check(run == exp_smp(ch_code(int'(cnv_ch))), "R5 window", run,
              exp_smp(ch_code(int'(cnv_ch))));
        after_stop = 1'b0;
        slot_at_start = pos;
        pos++;
        if (pos >= exp_count()) begin
          pos = 0;
          lap++;
        end
        gen++;
        last_data = DW'((int'(cnv_ch) << 7) ^ gen);
        cnv_data  = last_data;
        cd = CONV_LAT;
        n_start++;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic run_seq(string tag);
    int base;
    base = n_eoc;
    pos = 0;
    lap = 0;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    check(busy, "R2 start", int'(busy), 1);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(n_eoc - base == exp_count(), tag, n_eoc - base, exp_count());
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin : main
    int base, bst;
    void'($urandom(32'd7193));
    repeat (3) @(negedge clk);
    check(!busy && !cnv_sample && !eoc && !dma_req && !ovr && !cnv_start,
          "R1 in reset", int'({busy, cnv_sample, eoc, dma_req, ovr}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !cnv_sample && !eoc && !dma_req && !ovr,
          "R1 after reset", int'({busy, cnv_sample, eoc, dma_req, ovr}), 0);

    // R2: trigger ignored while disabled
    scan_en = 1'b1;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (10) @(negedge clk);
    check(!busy && !cnv_sample, "R2 ignored trig", int'(busy), 0);
    check(n_start == 0, "R2 no conversion", n_start, 0);
    en = 1'b1;

    // R3: repeated channels, code keyed by channel
    slot_list = '0;
    smp_table = '0;
    slot_list[0*CW +: CW] = 5'd9;
    slot_list[1*CW +: CW] = 5'd3;
    slot_list[2*CW +: CW] = 5'd9;
    slot_list[3*CW +: CW] = 5'd9;
    smp_table[9*3 +: 3] = 3'd1;
    smp_table[3*3 +: 3] = 3'd0;
    seq_len = 4'd3;
    run_seq("R3 repeat count");

    // R5: every sample code once
    for (int i = 0; i < 8; i++) begin
      slot_list[i*CW +: CW] = CW'(i + 8);
      smp_table[(i+8)*3 +: 3] = 3'(7 - i);
    end
    seq_len = 4'd7;
    run_seq("R5 all codes count");

    // R4: scan disabled ignores a long length
    scan_en = 1'b0;
    seq_len = 4'd15;
    run_seq("R4 single slot");
    scan_en = 1'b1;

    // R3: random lists
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < NS; i++) slot_list[i*CW +: CW] = CW'($urandom_range(0, NCH-1));
      for (int c = 0; c < NCH; c++) smp_table[c*3 +: 3] = 3'($urandom_range(0, 6));
      seq_len = 4'($urandom_range(0, 15));
      run_seq("R3 random count");
    end

    // R9 / R10: continuous run stopped through en
    slot_list[0*CW +: CW] = 5'd4;
    slot_list[1*CW +: CW] = 5'd7;
    slot_list[2*CW +: CW] = 5'd11;
    smp_table[4*3 +: 3]  = 3'd0;
    smp_table[7*3 +: 3]  = 3'd1;
    smp_table[11*3 +: 3] = 3'd0;
    seq_len = 4'd2;
    cont_en = 1'b1;
    pos = 0;
    lap = 0;
    bst = n_start;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    while (n_start - bst < 7) @(negedge clk);
    check(lap >= 2, "R9 restarted without trigger", lap, 2);
    do @(negedge clk); while (!eoc);
    #1;
    en = 1'b0;
    base = n_eoc;
    bst = n_start;
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check(n_eoc == base + 1, "R10 finishes current", n_eoc - base, 1);
    check(n_start == bst + 1, "R10 no new window", n_start - bst, 1);
    check(!cnv_sample && !busy, "R10 parked", int'(busy), 0);
    cont_en = 1'b0;
    en = 1'b1;
    after_stop = 1'b1;
    run_seq("R10 count after restart");

    // R8: overrun with acknowledges withheld
    auto_ack = 1'b0;
    seq_len = 4'd1;
    run_seq("R3 count no ack");
    check(ovr, "R8 overrun set", int'(ovr), 1);
    check(dma_req, "R7 req held", int'(dma_req), 1);
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    @(negedge clk);
    check(!dma_req, "R7 req cleared by ack", int'(dma_req), 0);
    check(ovr, "R8 overrun kept", int'(ovr), 1);
    auto_ack = 1'b1;
    pos = 0;
    lap = 0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    check(!ovr, "R8 cleared by trigger", int'(ovr), 1'b0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!ovr, "R8 stays clear with ack", int'(ovr), 0);

    summary();
    $finish;
  end

endmodule